// File: doc/BRIEF.md
# Supply-Loss Memory Guard

This block is a clocked supervisor that sits between two digitized supply comparators and a battery-backed static memory. One comparator reports that the main supply has sagged below the level at which the memory must stop accepting accesses; the other reports that it has sagged further, to the level at which the array must be fed from its backup cell. From these, plus a flag from the memory interface saying an access is under way, the guard drives three controls: a combined write-protect and deselect, a battery-select, and a tristate enable for the data outputs.

On a supply drop, an idle memory is protected at once, while an access in flight is given a bounded grace window to finish before protection is forced. When the supply sinks further, the battery is selected, and it is released again as the supply climbs back. Once the supply clears the deselect level again, protection is held for a long recovery count before normal access resumes. A fresh sag during that count sends the guard back to protection, and the full count starts over. Both comparator flags are synchronized and debounced before use, and every delay is a parameter counted in clocks.

Top module: `supply_guard`

## Requirements
- R1: While reset is asserted and right after it, the outputs read memProtect=1, dataHiZ=1, battSelect=0 (the pattern {memProtect,dataHiZ,battSelect}=3'b110). Protection is only lifted after the supply flag reads valid and the recovery count has elapsed.
- R2: A level change on either raw flag that stays steady first shows at the outputs exactly SYNC_STAGES+FILT_CYCLES+1 clocks after it is applied (the response latency LAT). supplyLowRaw=1 means the supply is below the deselect level. battLowRaw=1 means it is below the battery switchover level.
- R3: A raw flag pulse shorter than FILT_CYCLES clocks has no effect on the outputs. A pulse of exactly FILT_CYCLES clocks is accepted.
- R4: With cycleBusy=0, a supply drop in normal operation sets the pattern to 3'b110 exactly LAT clocks after supplyLowRaw rises.
- R5: With cycleBusy=1 when the drop is accepted, the outputs stay 3'b000. Protection is set one clock after cycleBusy falls, and no later than LAT+GRACE_CYCLES clocks after supplyLowRaw rose.
- R6: During protection, battLowRaw=1 selects the battery (pattern 3'b111) one clock after protection is set. Clearing it returns the pattern to 3'b110 LAT clocks later.
- R7: After supplyLowRaw falls, protection holds for LAT+RECOVER_CYCLES-1 clocks. The pattern returns to 3'b000 at clock LAT+RECOVER_CYCLES.
- R8: A supply sag accepted during recovery returns the guard to protection, and the full recovery count restarts from the moment the sag clears.
- R9: While protected, cycleBusy is ignored: toggling it leaves the pattern at 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyLowRaw | input | 1 | Comparator flag, supply below deselect level (asynchronous) |
| battLowRaw | input | 1 | Comparator flag, supply below battery switchover level (asynchronous) |
| cycleBusy | input | 1 | Memory access in progress |
| memProtect | output | 1 | Write-protect and deselect toward the array |
| battSelect | output | 1 | Feed the array from the backup cell |
| dataHiZ | output | 1 | Force the data outputs to high impedance |

## Verification
The assertions watch the following on every cycle:
- an idle drop or an ended access leads to protection on the next clock;
- an expired grace window forces protection;
- the debounced flags change only toward their synchronized input;
- both timers stay in range;
- protection is lifted only when the recovery count has completed and the supply flag reads valid.

The exact latencies need the bench's directed scenarios:
- the response latency itself;
- the filtering of short pulses and the acceptance boundary;
- a sag restarting the recovery count;
- cycleBusy being ignored during protection.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_GRACE,
    ST_PROTECT,
    ST_BATTERY,
    ST_RECOVER
  } guard_state_e;

  // Strobes from control to the timer datapath
  typedef struct packed {
    logic graceClr;
    logic graceStep;
    logic recClr;
    logic recStep;
  } timer_cmd_t;

endpackage

// File: rtl/supply_guard_filt.sv
module supply_guard_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 3,
  parameter bit RESET_VAL   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic flagOut
);

  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [CW-1:0]          runCnt;
  logic                   accQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= {SYNC_STAGES{RESET_VAL}};
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  // Accept a new level only after FILT_CYCLES consecutive disagreeing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= RESET_VAL;
      runCnt <= '0;
    end else if (syncOut != accQ) begin
      if (runCnt == CW'(FILT_CYCLES - 1)) begin
        accQ   <= syncOut;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      runCnt <= '0;
    end
  end

  assign flagOut = accQ;

  assert_flag_follows_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(accQ) |-> ($past(syncOut) == accQ));

  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < CW'(FILT_CYCLES));

endmodule

// File: rtl/supply_guard_dp.sv
module supply_guard_dp
  import supply_guard_pkg::*;
#(
  parameter int GRACE_CYCLES   = 16,
  parameter int RECOVER_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  timer_cmd_t cmd,
  output logic       graceDone,
  output logic       recDone
);

  localparam int GW = $clog2(GRACE_CYCLES + 1);
  localparam int RW = $clog2(RECOVER_CYCLES + 1);

  logic [GW-1:0] graceCnt;
  logic [RW-1:0] recCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              graceCnt <= '0;
    else if (cmd.graceClr)  graceCnt <= '0;
    else if (cmd.graceStep) graceCnt <= graceCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            recCnt <= '0;
    else if (cmd.recClr)  recCnt <= '0;
    else if (cmd.recStep) recCnt <= recCnt + 1'b1;
  end

  assign graceDone = (graceCnt == GW'(GRACE_CYCLES - 1));
  assign recDone   = (recCnt == RW'(RECOVER_CYCLES - 1));

  assert_grace_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    graceCnt < GW'(GRACE_CYCLES));

  assert_recover_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    recCnt < RW'(RECOVER_CYCLES));

endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import supply_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowFlag,
  input  logic       battFlag,
  input  logic       cycleBusy,
  input  logic       graceDone,
  input  logic       recDone,
  output timer_cmd_t cmd,
  output logic       protectOut,
  output logic       battOut,
  output logic       hiZOut
);

  guard_state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_PROTECT;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    unique case (stateQ)
      ST_NORMAL: begin
        if (lowFlag) begin
          if (cycleBusy) begin
            stateD       = ST_GRACE;
            cmd.graceClr = 1'b1;
          end else begin
            stateD = ST_PROTECT;
          end
        end
      end
      ST_GRACE: begin
        if (!cycleBusy || graceDone) stateD = ST_PROTECT;
        else                         cmd.graceStep = 1'b1;
      end
      ST_PROTECT: begin
        if (battFlag) begin
          stateD = ST_BATTERY;
        end else if (!lowFlag) begin
          stateD     = ST_RECOVER;
          cmd.recClr = 1'b1;
        end
      end
      ST_BATTERY: begin
        if (!battFlag) stateD = ST_PROTECT;
      end
      ST_RECOVER: begin
        if (lowFlag)      stateD = ST_PROTECT;
        else if (recDone) stateD = ST_NORMAL;
        else              cmd.recStep = 1'b1;
      end
      default: stateD = ST_PROTECT;
    endcase
  end

  assign protectOut = (stateQ != ST_NORMAL) && (stateQ != ST_GRACE);
  assign hiZOut     = protectOut;
  assign battOut    = (stateQ == ST_BATTERY);

  assert_idle_drop_protects_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_NORMAL && lowFlag && !cycleBusy) |=> protectOut);

  assert_access_end_protects_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GRACE && !cycleBusy) |=> protectOut);

  assert_grace_expiry_protects_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GRACE && graceDone) |=> protectOut);

  assert_battery_needs_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(battOut) |-> $past(battFlag));

  assert_release_after_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protectOut) |-> ($past(recDone) && !$past(lowFlag)));

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int FILT_CYCLES    = 3,
  parameter int GRACE_CYCLES   = 16,
  parameter int RECOVER_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLowRaw,
  input  logic battLowRaw,
  input  logic cycleBusy,
  output logic memProtect,
  output logic battSelect,
  output logic dataHiZ
);

  localparam int NFLAGS = 2;

  logic [NFLAGS-1:0] rawVec;
  logic [NFLAGS-1:0] flagVec;
  timer_cmd_t        cmd;
  logic              graceDone;
  logic              recDone;

  assign rawVec = {battLowRaw, supplyLowRaw};

  // Index 0: deselect-level flag (resets to "low"), index 1: switchover flag
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    supply_guard_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES),
      .RESET_VAL  (i == 0)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawVec[i]),
      .flagOut(flagVec[i])
    );
  end

  supply_guard_dp #(
    .GRACE_CYCLES  (GRACE_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .graceDone(graceDone),
    .recDone  (recDone)
  );

  supply_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lowFlag   (flagVec[0]),
    .battFlag  (flagVec[1]),
    .cycleBusy (cycleBusy),
    .graceDone (graceDone),
    .recDone   (recDone),
    .cmd       (cmd),
    .protectOut(memProtect),
    .battOut   (battSelect),
    .hiZOut    (dataHiZ)
  );

endmodule

// File: tb/supply_guard_test.sv
module supply_guard_test;

  localparam int SYNC  = 2;
  localparam int FILT  = 3;
  localparam int GRACE = 16;
  localparam int REC   = 64;
  localparam int LAT   = SYNC + FILT + 1;

  logic clk = 1'b0;
  logic rstN;
  logic supplyLowRaw, battLowRaw, cycleBusy;
  logic memProtect, battSelect, dataHiZ;

  int checks = 0;
  int errors = 0;

  supply_guard #(
    .SYNC_STAGES(SYNC), .FILT_CYCLES(FILT),
    .GRACE_CYCLES(GRACE), .RECOVER_CYCLES(REC)
  ) uut (
    .clk(clk), .rstN(rstN), .supplyLowRaw(supplyLowRaw), .battLowRaw(battLowRaw),
    .cycleBusy(cycleBusy), .memProtect(memProtect), .battSelect(battSelect),
    .dataHiZ(dataHiZ)
  );

  always #2.5 clk = ~clk;

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [2:0] exp);
    logic [2:0] act;
    act = {memProtect, dataHiZ, battSelect};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic goNormal();
    supplyLowRaw = 1'b0;
    battLowRaw   = 1'b0;
    cycleBusy    = 1'b0;
    step(LAT + REC + 2);
    chk("R7 back to normal", 3'b000);
  endtask

  task automatic t_reset();
    rstN = 1'b0; supplyLowRaw = 1'b1; battLowRaw = 1'b0; cycleBusy = 1'b0;
    step(3);
    chk("R1 in reset", 3'b110);
    rstN = 1'b1;
    supplyLowRaw = 1'b0;
    step(1);
    chk("R1 after release", 3'b110);
    step(LAT + REC - 2);
    chk("R1 still held", 3'b110);
    step(1);
    chk("R1 released", 3'b000);
  endtask

  task automatic t_idle_drop();
    supplyLowRaw = 1'b1;
    step(LAT - 1);
    chk("R4 before latency", 3'b000);
    step(1);
    chk("R4 protected", 3'b110);
    supplyLowRaw = 1'b0;
    step(LAT + REC - 1);
    chk("R7 held through count", 3'b110);
    step(1);
    chk("R7 released", 3'b000);
  endtask

  task automatic t_glitch();
    supplyLowRaw = 1'b1;
    step(FILT - 1);
    supplyLowRaw = 1'b0;
    for (int i = 0; i < 4 * LAT; i++) begin
      step(1);
      chk("R3 short pulse ignored", 3'b000);
    end
    supplyLowRaw = 1'b1;
    step(FILT);
    supplyLowRaw = 1'b0;
    step(LAT - FILT);
    chk("R3 boundary pulse accepted", 3'b110);
    goNormal();
  endtask

  task automatic t_grace_release();
    cycleBusy = 1'b1;
    supplyLowRaw = 1'b1;
    step(LAT);
    chk("R5 grace open", 3'b000);
    step(3);
    chk("R5 grace continues", 3'b000);
    cycleBusy = 1'b0;
    step(1);
    chk("R5 access ended", 3'b110);
    goNormal();
  endtask

  task automatic t_grace_timeout();
    cycleBusy = 1'b1;
    supplyLowRaw = 1'b1;
    step(LAT + GRACE - 1);
    chk("R5 last grace clock", 3'b000);
    step(1);
    chk("R5 grace forced", 3'b110);
    goNormal();
  endtask

  task automatic t_busy_ignored();
    supplyLowRaw = 1'b1;
    step(LAT);
    chk("R9 protected", 3'b110);
    for (int i = 0; i < 8; i++) begin
      cycleBusy = ~cycleBusy;
      step(1);
      chk("R9 busy ignored", 3'b110);
    end
    goNormal();
  endtask

  task automatic t_battery();
    supplyLowRaw = 1'b1;
    battLowRaw   = 1'b1;
    step(LAT);
    chk("R6 protect first", 3'b110);
    step(1);
    chk("R6 battery selected", 3'b111);
    step(10);
    chk("R6 battery held", 3'b111);
    battLowRaw = 1'b0;
    step(LAT - 1);
    chk("R2 battery before latency", 3'b111);
    step(1);
    chk("R2 battery released", 3'b110);
    goNormal();
  endtask

  task automatic t_dip();
    supplyLowRaw = 1'b1;
    step(LAT);
    chk("R8 protected", 3'b110);
    supplyLowRaw = 1'b0;
    step(LAT + REC / 2);
    chk("R8 mid recovery", 3'b110);
    supplyLowRaw = 1'b1;
    step(LAT + 2);
    chk("R8 sag during recovery", 3'b110);
    supplyLowRaw = 1'b0;
    step(LAT + REC - 1);
    chk("R8 count restarted", 3'b110);
    step(1);
    chk("R8 released after full count", 3'b000);
  endtask

  initial begin
    t_reset();
    t_idle_drop();
    t_glitch();
    t_grace_release();
    t_grace_timeout();
    t_busy_ignored();
    t_battery();
    t_dip();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired at %0t: actual hung expected done", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule